// File: doc/BRIEF.md
# Drift-Triggered Stepping Frequency Governor

This block picks a clock frequency level for one compute tile from the fill level of that tile's output buffer. It compares the fill level with a setpoint. When the buffer holds too little data it raises the level by one, and when it holds too much it lowers the level by one. It never jumps by more than one level in one decision, and it stays inside a fixed range of discrete levels.

The block does not act every cycle. It keeps a reference copy of the fill level taken at its last decision. It evaluates again only when the live fill level has moved away from that reference by more than a programmable drift amount, which keeps the number of frequency switches low. A mode input chooses between two decision rules. The first compares directly against the setpoint. The second uses a hysteresis band of roughly ±10% around the setpoint, and inside that band the level holds. Each level change is flagged with a one-cycle strobe for the clock generator downstream.

Top module: `fill_step_governor`

## Requirements
- R1: While `rst_n` is low, `freq_idx` is NUM_LEVELS-1 (5 by default), `step_pulse` is 0, and the drift reference is loaded from `fill_lvl` on every clock.
- R2: An evaluation is triggered in a cycle only when |`fill_lvl` − reference| is strictly greater than `trig_delta`. A drift equal to `trig_delta` or smaller causes no level change and no strobe.
- R3: The reference is reloaded with `fill_lvl` only in a cycle where an evaluation is triggered, whether or not that evaluation changes the level. Small moves in one direction therefore add up until they exceed `trig_delta`.
- R4: With `hyst_en`=0, a triggered evaluation raises `freq_idx` by one when `fill_lvl` < `set_lvl`, lowers it by one when `fill_lvl` > `set_lvl`, and holds it when they are equal.
- R5: With `hyst_en`=1, let off = floor(`set_lvl`·13/128), low = `set_lvl` − off and high = `set_lvl` + off. A triggered evaluation raises the level only when `fill_lvl` < low, lowers it only when `fill_lvl` > high, and holds it for any fill level from low to high inclusive.
- R6: `freq_idx` stays within 0..NUM_LEVELS-1. A raise at the top level or a lower at level 0 leaves the level unchanged and gives no strobe.
- R7: `freq_idx` and `step_pulse` are registered. The result of the inputs sampled at a clock edge appears right after that edge. `step_pulse` is high for exactly the cycles in which `freq_idx` changed, and every change is by exactly one.
- R8: `hyst_en` is sampled together with the fill level on every evaluation, so the rule can change from one decision to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_lvl | input | OCC_W | Current buffer occupancy |
| set_lvl | input | OCC_W | Occupancy setpoint |
| trig_delta | input | OCC_W | Drift needed before a new evaluation |
| hyst_en | input | 1 | 1 selects the hysteresis-band rule, 0 the plain setpoint rule |
| freq_idx | output | LVL_W | Frequency level index, 0 = slowest |
| step_pulse | output | 1 | One-cycle strobe on each level change |

## Verification
The decision rule is first driven with directed fill levels placed exactly at drift boundaries, one above and one at `trig_delta`. These show the difference between a strict and a non-strict trigger comparison. Next come a slow ramp that accumulates sub-threshold drift, which shows whether the reference is reloaded only on triggers, and fill levels just inside and just outside the hysteresis band, which show whether the band edges are inclusive. Repeated large swings drive the level into both saturation limits. The same fill level is also evaluated under both modes, so a rule ignoring `hyst_en` is exposed. A long random walk of occupancy, with setpoint, drift amount and mode changing along the way, then exercises mixed sequences against a bench reference model.

// File: rtl/gov_pkg.sv
// Package: shared types for the drift-triggered frequency governor.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package gov_pkg;
    // Direction requested by one evaluation.
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_RAISE = 2'd1,
        STEP_LOWER = 2'd2
    } step_dir_e;
endpackage

// File: rtl/gov_band_calc.sv
// Module: gov_band_calc
// Derives the hysteresis band edges as setpoint -/+ (setpoint*HYST_NUM >> HYST_SHIFT),
// using shift-add terms chosen by the set bits of HYST_NUM. Assumes
// HYST_NUM < 2**HYST_SHIFT, so the offset never exceeds the setpoint.
// The outputs are one bit wider than the setpoint so that the high edge cannot wrap.
module gov_band_calc #(
    parameter int OCC_W      = 10,
    parameter int HYST_NUM   = 13,
    parameter int HYST_SHIFT = 7
) (
    input  logic [OCC_W-1:0] set_lvl,
    output logic [OCC_W:0]   band_lo,
    output logic [OCC_W:0]   band_hi
);
    localparam int NUM_W  = $clog2(HYST_NUM + 1);
    localparam int PROD_W = OCC_W + NUM_W;
    localparam logic [NUM_W-1:0] NUM_BITS = NUM_W'(HYST_NUM);

    logic [PROD_W-1:0] term [NUM_W];
    logic [PROD_W-1:0] prod;
    logic [OCC_W-1:0]  offset;

    // One shifted copy of the setpoint for each set bit of the multiplier.
    for (genvar i = 0; i < NUM_W; i++) begin : g_term
        if (NUM_BITS[i]) begin : g_on
            assign term[i] = PROD_W'(set_lvl) << i;
        end else begin : g_off
            assign term[i] = '0;
        end
    end

    // Sum the partial products.
    always_comb begin
        prod = '0;
        for (int i = 0; i < NUM_W; i++) begin
            prod = prod + term[i];
        end
    end

    assign offset  = OCC_W'(prod >> HYST_SHIFT);
    assign band_lo = {1'b0, set_lvl} - {1'b0, offset};
    assign band_hi = {1'b0, set_lvl} + {1'b0, offset};
endmodule

// File: rtl/gov_drift_watch.sv
// Module: gov_drift_watch
// Holds the fill level seen at the last evaluation and raises `fire` when the
// live fill level has moved from it by strictly more than trig_delta.
// Assumes a synchronous active-low reset. During reset the reference follows the input.
module gov_drift_watch #(
    parameter int OCC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] fill_lvl,
    input  logic [OCC_W-1:0] trig_delta,
    output logic             fire
);
    logic [OCC_W-1:0] ref_lvl;
    logic [OCC_W-1:0] drift;

    // Absolute distance between the live level and the reference.
    always_comb begin
        if (fill_lvl >= ref_lvl) drift = fill_lvl - ref_lvl;
        else                     drift = ref_lvl - fill_lvl;
        fire = (drift > trig_delta);
    end

    // Reload the reference during reset and on each triggered evaluation only.
    always_ff @(posedge clk) begin
        if (!rst_n)    ref_lvl <= fill_lvl;
        else if (fire) ref_lvl <= fill_lvl;
    end
endmodule

// File: rtl/gov_step_pick.sv
// Module: gov_step_pick
// Chooses raise, lower or hold for a triggered evaluation. In plain mode it compares
// against the setpoint. In band mode it compares against the band edges, which are inclusive.
// Assumes the band edges come from gov_band_calc for the same setpoint.
module gov_step_pick
    import gov_pkg::*;
#(
    parameter int OCC_W = 10
) (
    input  logic             fire,
    input  logic             hyst_en,
    input  logic [OCC_W-1:0] fill_lvl,
    input  logic [OCC_W-1:0] set_lvl,
    input  logic [OCC_W:0]   band_lo,
    input  logic [OCC_W:0]   band_hi,
    output step_dir_e        dir
);
    logic [OCC_W:0] fill_x;
    logic [OCC_W:0] up_edge;
    logic [OCC_W:0] dn_edge;

    // Select the comparison edges for the active rule.
    always_comb begin
        fill_x  = {1'b0, fill_lvl};
        up_edge = hyst_en ? band_lo : {1'b0, set_lvl};
        dn_edge = hyst_en ? band_hi : {1'b0, set_lvl};
    end

    // Request a direction only when an evaluation fired.
    always_comb begin
        dir = STEP_HOLD;
        if (fire) begin
            if (fill_x < up_edge)      dir = STEP_RAISE;
            else if (fill_x > dn_edge) dir = STEP_LOWER;
        end
    end
endmodule

// File: rtl/gov_level_step.sv
// Module: gov_level_step
// Saturating level register moving one step per request, with a strobe for each
// real change. Assumes synchronous active-low reset to the top level.
module gov_level_step
    import gov_pkg::*;
#(
    parameter int NUM_LEVELS = 6,
    parameter int LVL_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_dir_e        dir,
    output logic [LVL_W-1:0] freq_idx,
    output logic             step_pulse
);
    localparam logic [LVL_W-1:0] TOP = LVL_W'(NUM_LEVELS - 1);

    logic [LVL_W-1:0] nxt_idx;
    logic             nxt_pulse;

    // Next level with saturation at both ends.
    always_comb begin
        nxt_idx   = freq_idx;
        nxt_pulse = 1'b0;
        unique case (dir)
            STEP_RAISE: if (freq_idx < TOP) begin
                nxt_idx   = freq_idx + 1'b1;
                nxt_pulse = 1'b1;
            end
            STEP_LOWER: if (freq_idx != '0) begin
                nxt_idx   = freq_idx - 1'b1;
                nxt_pulse = 1'b1;
            end
            default: ;
        endcase
    end

    // Register the level and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_idx   <= TOP;
            step_pulse <= 1'b0;
        end else begin
            freq_idx   <= nxt_idx;
            step_pulse <= nxt_pulse;
        end
    end
endmodule

// File: rtl/fill_step_governor.sv
// Module: fill_step_governor (top)
// Drift-triggered, one-step-at-a-time frequency level governor driven by buffer fill.
// Assumes fill_lvl, set_lvl and trig_delta are synchronous to clk. Reset is synchronous, active low.
module fill_step_governor
    import gov_pkg::*;
#(
    parameter int OCC_W      = 10,
    parameter int NUM_LEVELS = 6,
    parameter int HYST_NUM   = 13,
    parameter int HYST_SHIFT = 7,
    localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] fill_lvl,
    input  logic [OCC_W-1:0] set_lvl,
    input  logic [OCC_W-1:0] trig_delta,
    input  logic             hyst_en,
    output logic [LVL_W-1:0] freq_idx,
    output logic             step_pulse
);
    logic           fire;
    logic [OCC_W:0] band_lo;
    logic [OCC_W:0] band_hi;
    step_dir_e      dir;

    gov_band_calc #(
        .OCC_W(OCC_W), .HYST_NUM(HYST_NUM), .HYST_SHIFT(HYST_SHIFT)
    ) u_band (
        .set_lvl(set_lvl), .band_lo(band_lo), .band_hi(band_hi)
    );

    gov_drift_watch #(.OCC_W(OCC_W)) u_drift (
        .clk(clk), .rst_n(rst_n), .fill_lvl(fill_lvl),
        .trig_delta(trig_delta), .fire(fire)
    );

    gov_step_pick #(.OCC_W(OCC_W)) u_pick (
        .fire(fire), .hyst_en(hyst_en), .fill_lvl(fill_lvl), .set_lvl(set_lvl),
        .band_lo(band_lo), .band_hi(band_hi), .dir(dir)
    );

    gov_level_step #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_level (
        .clk(clk), .rst_n(rst_n), .dir(dir),
        .freq_idx(freq_idx), .step_pulse(step_pulse)
    );
endmodule

// File: rtl/gov_checker.sv
// Module: gov_checker
// Property checks on the governor's ports, attached to every instance by bind.
// Assumes the same parameter values as the governor instance.
module gov_checker #(
    parameter int OCC_W      = 10,
    parameter int NUM_LEVELS = 6,
    parameter int HYST_NUM   = 13,
    parameter int HYST_SHIFT = 7,
    parameter int LVL_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OCC_W-1:0] fill_lvl,
    input logic [OCC_W-1:0] set_lvl,
    input logic [OCC_W-1:0] trig_delta,
    input logic             hyst_en,
    input logic [LVL_W-1:0] freq_idx,
    input logic             step_pulse
);
    int   off_i;
    logic in_band;

    // Band membership computed by plain multiplication, apart from the shift-add datapath.
    always_comb begin
        off_i   = (int'(set_lvl) * HYST_NUM) / (1 << HYST_SHIFT);
        in_band = hyst_en && (int'(fill_lvl) >= int'(set_lvl) - off_i)
                          && (int'(fill_lvl) <= int'(set_lvl) + off_i);
    end

    p_reset_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (int'(freq_idx) == NUM_LEVELS - 1) && !step_pulse);

    p_level_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(freq_idx) <= NUM_LEVELS - 1);

    p_one_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> (int'(freq_idx) == int'($past(freq_idx)) + 1) ||
                       (int'(freq_idx) + 1 == int'($past(freq_idx))));

    p_pulse_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (step_pulse == (freq_idx != $past(freq_idx))));

    p_raise_below_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && step_pulse && ($past(fill_lvl) < $past(set_lvl)))
        |-> (freq_idx > $past(freq_idx)));

    p_lower_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && step_pulse && ($past(fill_lvl) > $past(set_lvl)))
        |-> (freq_idx < $past(freq_idx)));

    p_equal_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fill_lvl == set_lvl) |-> !step_pulse);

    p_band_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_band) |-> !step_pulse);
endmodule

bind fill_step_governor gov_checker #(
    .OCC_W(OCC_W), .NUM_LEVELS(NUM_LEVELS), .HYST_NUM(HYST_NUM),
    .HYST_SHIFT(HYST_SHIFT), .LVL_W(LVL_W)
) u_gov_checker (.*);

// File: tb/tb_fill_step_governor.sv
// Bench: directed corner cases plus a seeded random walk, checked against a bench model.
module tb_fill_step_governor;
    localparam int OCC_W  = 10;
    localparam int NLV    = 6;
    localparam int LVL_W  = $clog2(NLV);
    localparam int OCC_MX = (1 << OCC_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [OCC_W-1:0] fill_lvl, set_lvl, trig_delta;
    logic             hyst_en;
    logic [LVL_W-1:0] freq_idx;
    logic             step_pulse;

    int n_chk = 0, n_fail = 0;
    int m_lvl, m_ref;
    bit done = 0;

    fill_step_governor #(.OCC_W(OCC_W), .NUM_LEVELS(NLV)) dut (
        .clk(clk), .rst_n(rst_n), .fill_lvl(fill_lvl), .set_lvl(set_lvl),
        .trig_delta(trig_delta), .hyst_en(hyst_en),
        .freq_idx(freq_idx), .step_pulse(step_pulse)
    );

    always #5 clk = ~clk;

    function automatic int band_off(int sp);
        return (sp * 13) / 128;
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One sample: drive at negedge, model the edge, compare just after the edge.
    task automatic sample(int occ, int sp, int d, bit mode, string tag);
        int  diff, nl;
        bit  fire, up, dn, pulse;
        string t;
        diff = (occ > m_ref) ? occ - m_ref : m_ref - occ;
        fire = diff > d;
        up = 0; dn = 0;
        if (fire) begin
            m_ref = occ;
            if (mode) begin
                up = occ < sp - band_off(sp);
                dn = occ > sp + band_off(sp);
            end else begin
                up = occ < sp;
                dn = occ > sp;
            end
        end
        nl = m_lvl;
        if (up && m_lvl < NLV - 1) nl = m_lvl + 1;
        if (dn && m_lvl > 0)       nl = m_lvl - 1;
        pulse = (nl != m_lvl);
        m_lvl = nl;
        if (tag != "") t = tag;
        else if (!fire) t = "R2";
        else if ((up || dn) && !pulse) t = "R6";
        else if (mode) t = "R5";
        else t = "R4";
        @(negedge clk);
        fill_lvl = OCC_W'(occ); set_lvl = OCC_W'(sp);
        trig_delta = OCC_W'(d); hyst_en = mode;
        @(posedge clk); #1;
        check(t, int'(freq_idx), m_lvl, "level");
        check("R7", int'(step_pulse), int'(pulse), "strobe");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int occ, sp, d;
        bit mode;
        void'($urandom(32'd4242));
        rst_n = 0; fill_lvl = 10'd100; set_lvl = 10'd200; trig_delta = 10'd10; hyst_en = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", int'(freq_idx), NLV - 1, "reset level");
        check("R1", int'(step_pulse), 0, "reset strobe");
        m_lvl = NLV - 1; m_ref = 100;
        @(negedge clk); rst_n = 1;

        // R2: drift equal to delta does not trigger; R1: reference came from reset-time input
        sample(110, 200, 10, 0, "R2");
        // one past the delta triggers; raise requested at the top level saturates (R6)
        sample(111, 200, 10, 0, "R6");
        // large positive drift above setpoint lowers one level (R4)
        sample(300, 200, 10, 0, "R4");
        // R3: ramp by delta from reference 300: first move holds, accumulated move fires
        sample(290, 200, 10, 0, "R3");
        sample(280, 200, 10, 0, "R3");
        // R4: equal to setpoint after a trigger holds
        sample(200, 200, 10, 0, "R4");
        // R5: setpoint 200 -> band 180..220; edges inclusive hold
        sample(220, 200, 10, 1, "R5");
        sample(180, 200, 10, 1, "R5");
        sample(221, 200, 10, 1, "R5");
        sample(179, 200, 10, 1, "R5");
        // R8: same fill level, mode chosen per sample
        sample(150, 200, 10, 0, "R8");
        sample(210, 200, 10, 1, "R8");
        sample(150, 200, 10, 0, "R8");
        sample(210, 200, 10, 0, "R8");
        // R6: drive down to level 0 then try further
        for (int i = 0; i < 8; i++) sample((i % 2) ? 500 : 900, 100, 10, 0, "R6");
        // R6: drive back up to the top then try further
        for (int i = 0; i < 8; i++) sample((i % 2) ? 10 : 60, 800, 10, 0, "R6");

        // Random walk of occupancy with occasional setpoint, delta and mode changes.
        occ = 400; sp = 400; d = 8; mode = 0;
        for (int i = 0; i < 4000; i++) begin
            occ = occ + int'($urandom_range(80)) - 40;
            if (occ < 0) occ = 0;
            if (occ > OCC_MX) occ = OCC_MX;
            if ($urandom_range(31) == 0) sp = 100 + int'($urandom_range(800));
            if ($urandom_range(15) == 0) d = int'($urandom_range(30));
            if ($urandom_range(7) == 0) mode = 1'($urandom_range(1));
            sample(occ, sp, d, mode, "");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule